// File: doc/BRIEF.md
# Bit-matrix ALU unit

This execution unit works on 64-bit values that it reads as 8x8 matrices of bits. Byte r of a value is row r, and bit c of that byte is column c. The unit supports three operations. It can transpose one matrix. It can multiply two matrices with Boolean arithmetic, where a sum is an OR. It can also multiply them over GF(2), where a sum is an XOR. It decodes the raw 32-bit instruction word itself. For each accepted request it returns one result, together with a flag that marks words it does not support.

Requests enter on a valid/ready pair, together with the instruction word and two operands. One cycle after a request is accepted, the registered result appears on an output valid/ready pair. It stays there until the consumer takes it. A new request is accepted in the same cycle that the previous result is consumed, so the unit can stream one operation per clock. The datapath width is a parameter. When the width is anything other than 64, the unit reports every request as unsupported.

Top module: `bitmat_unit`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `out_result` is zero until the first request is accepted.
- R2: Transpose sends input bit 8*j+k to result bit 8*k+j, for j and k in 0..7. The value of `src_b` does not change the result.
- R3: Boolean product: result bit 8*r+c is the OR over m in 0..7 of (`src_a` bit 8*r+m AND `src_b` bit 8*m+c).
- R4: GF(2) product: result bit 8*r+c is the XOR over m in 0..7 of (`src_a` bit 8*r+m AND `src_b` bit 8*m+c).
- R5: The instruction word selects the operation as follows. Transpose needs instr[31:25]=0110000, instr[24:20]=00011, instr[14:12]=001 and instr[6:0]=0010011. Boolean product needs instr[31:25]=0000100, instr[14:12]=011 and instr[6:0]=0110011. GF(2) product needs instr[31:25]=0100100 with the same instr[14:12] and instr[6:0]. The register-number fields instr[19:15] and instr[11:7] are ignored. For the products, instr[24:20] is also ignored.
- R6: A word that matches none of the three encodings gives `out_illegal`=1 and `out_result`=0. A supported word gives `out_illegal`=0.
- R7: A request accepted at a clock edge (`in_valid` and `in_ready` both high) makes `out_valid` 1 after that edge, carrying its result. A cycle in which no request is accepted and the output is empty or consumed leaves `out_valid` at 0.
- R8: While `out_valid` is 1 and `out_ready` is 0, the result and flag hold their values.
- R9: `in_ready` is 1 exactly when `out_valid` is 0 or `out_ready` is 1.
- R10: When the width parameter XLEN is not 64, every accepted request completes with `out_illegal`=1 and `out_result`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| in_valid | input | 1 | A request is present |
| in_ready | output | 1 | The unit can take a request this cycle |
| instr | input | 32 | Raw instruction word |
| src_a | input | XLEN | First operand (matrix A) |
| src_b | input | XLEN | Second operand (matrix B), ignored by transpose |
| out_valid | output | 1 | A result is present |
| out_ready | input | 1 | The consumer takes the result this cycle |
| out_result | output | XLEN | Operation result |
| out_illegal | output | 1 | The instruction word was not supported |

## Verification
The two functions that meet in a single cycle are the draining of a held result and the acceptance of the next request. The bench provokes this by streaming requests while `out_ready` toggles randomly, so some edges both consume a result and load a new one, and other edges stall with a request waiting. A behavioural queue model predicts `in_ready`, `out_valid` and the front result on every clock. This catches any result that is lost or duplicated, any request accepted during a stall, and any held value that changes while stalled.

// File: rtl/bitmat_pkg.sv
package bitmat_pkg;

  localparam int BM_DIM = 8;

  typedef enum logic [1:0] {
    OP_NONE    = 2'd0,
    OP_FLIP    = 2'd1,
    OP_ORPROD  = 2'd2,
    OP_XORPROD = 2'd3
  } bm_op_e;

  localparam logic [6:0] ENC_OPC_IMM  = 7'b0010011;
  localparam logic [6:0] ENC_OPC_REG  = 7'b0110011;
  localparam logic [6:0] ENC_FLIP_F7  = 7'b0110000;
  localparam logic [4:0] ENC_FLIP_SUB = 5'b00011;
  localparam logic [2:0] ENC_FLIP_F3  = 3'b001;
  localparam logic [2:0] ENC_PROD_F3  = 3'b011;
  localparam logic [6:0] ENC_OR_F7    = 7'b0000100;
  localparam logic [6:0] ENC_XOR_F7   = 7'b0100100;

endpackage

// File: rtl/bitmat_decode.sv
module bitmat_decode
  import bitmat_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [31:0] instr,
  output bm_op_e      op
);

  localparam int WIDE = BM_DIM * BM_DIM;

  logic [6:0] f7;
  logic [4:0] sub;
  logic [2:0] f3;
  logic [6:0] opc;

  assign f7  = instr[31:25];
  assign sub = instr[24:20];
  assign f3  = instr[14:12];
  assign opc = instr[6:0];

  generate
    if (XLEN == WIDE) begin : g_full
      always_comb begin
        op = OP_NONE;
        if (f7 == ENC_FLIP_F7 && sub == ENC_FLIP_SUB &&
            f3 == ENC_FLIP_F3 && opc == ENC_OPC_IMM) begin
          op = OP_FLIP;
        end else if (f3 == ENC_PROD_F3 && opc == ENC_OPC_REG) begin
          if (f7 == ENC_OR_F7) begin
            op = OP_ORPROD;
          end else if (f7 == ENC_XOR_F7) begin
            op = OP_XORPROD;
          end
        end
      end
    end else begin : g_unsupported
      assign op = OP_NONE;
    end
  endgenerate

endmodule

// File: rtl/bitmat_transpose.sv
module bitmat_transpose #(
  parameter int DIM = 8
) (
  input  logic [DIM*DIM-1:0] m_in,
  output logic [DIM*DIM-1:0] m_out
);

  generate
    for (genvar j = 0; j < DIM; j++) begin : g_row
      for (genvar k = 0; k < DIM; k++) begin : g_col
        assign m_out[k*DIM + j] = m_in[j*DIM + k];
      end
    end
  endgenerate

endmodule

// File: rtl/bitmat_product.sv
module bitmat_product #(
  parameter int DIM = 8
) (
  input  logic [DIM*DIM-1:0] row_src,
  input  logic [DIM*DIM-1:0] col_src_t,
  input  logic               use_parity,
  output logic [DIM*DIM-1:0] prod
);

  generate
    for (genvar r = 0; r < DIM; r++) begin : g_r
      for (genvar c = 0; c < DIM; c++) begin : g_c
        logic [DIM-1:0] conj;
        assign conj = row_src[r*DIM +: DIM] & col_src_t[c*DIM +: DIM];
        assign prod[r*DIM + c] = use_parity ? (^conj) : (|conj);
      end
    end
  endgenerate

endmodule

// File: rtl/bitmat_unit.sv
module bitmat_unit
  import bitmat_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_result,
  output logic            out_illegal
);

  localparam int DIM = BM_DIM;
  localparam int MW  = DIM * DIM;

  bm_op_e          op;
  logic [XLEN-1:0] exec_res;
  logic            exec_ill;
  logic            take;

  logic            valid_q, valid_d;
  logic [XLEN-1:0] res_q, res_d;
  logic            ill_q, ill_d;

  bitmat_decode #(.XLEN(XLEN)) u_dec (
    .instr (instr),
    .op    (op)
  );

  generate
    if (XLEN == MW) begin : g_wide
      logic [MW-1:0] a_t;
      logic [MW-1:0] b_t;
      logic [MW-1:0] prod;

      bitmat_transpose #(.DIM(DIM)) u_flip_a (
        .m_in  (src_a),
        .m_out (a_t)
      );

      bitmat_transpose #(.DIM(DIM)) u_flip_b (
        .m_in  (src_b),
        .m_out (b_t)
      );

      bitmat_product #(.DIM(DIM)) u_prod (
        .row_src    (src_a),
        .col_src_t  (b_t),
        .use_parity (op == OP_XORPROD),
        .prod       (prod)
      );

      always_comb begin
        unique case (op)
          OP_FLIP:    exec_res = a_t;
          OP_ORPROD:  exec_res = prod;
          OP_XORPROD: exec_res = prod;
          default:    exec_res = '0;
        endcase
      end
    end else begin : g_narrow
      assign exec_res = '0;
    end
  endgenerate

  assign exec_ill = (op == OP_NONE);
  assign in_ready = !valid_q || out_ready;
  assign take     = in_valid && in_ready;

  always_comb begin
    valid_d = valid_q;
    res_d   = res_q;
    ill_d   = ill_q;
    if (take) begin
      valid_d = 1'b1;
      res_d   = exec_res;
      ill_d   = exec_ill;
    end else if (out_ready) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
      ill_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      res_q   <= res_d;
      ill_q   <= ill_d;
    end
  end

  assign out_valid   = valid_q;
  assign out_result  = res_q;
  assign out_illegal = ill_q;

endmodule

// File: rtl/bitmat_unit_sva.sv
module bitmat_unit_sva #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [XLEN-1:0] out_result,
  input logic            out_illegal
);

  AST_RESET_EMPTY: assert property (@(posedge clk) !rst_n |-> !out_valid && out_result == '0); // R1

  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> out_result == '0); // R6

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R7

  AST_IDLE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) && (!out_valid || out_ready) |=> !out_valid); // R7

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_illegal)); // R8

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R9

  AST_DRAIN_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid || out_ready) |-> in_ready); // R9

  generate
    if (XLEN != 64) begin : g_narrow_chk
      AST_NARROW_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_illegal); // R10
    end
  endgenerate

endmodule

bind bitmat_unit bitmat_unit_sva #(.XLEN(XLEN)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_result  (out_result),
  .out_illegal (out_illegal)
);

// File: tb/bitmat_unit_bench.sv
`timescale 1ns/1ps
module bitmat_unit_bench;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] instr;
  logic [63:0] src_a;
  logic [63:0] src_b;
  logic        out_valid;
  logic        out_ready;
  logic [63:0] out_result;
  logic        out_illegal;

  logic        n_in_valid;
  logic        n_in_ready;
  logic [31:0] n_instr;
  logic [31:0] n_src_a;
  logic [31:0] n_src_b;
  logic        n_out_valid;
  logic        n_out_ready;
  logic [31:0] n_out_result;
  logic        n_out_illegal;

  int checks = 0;
  int errors = 0;
  logic [64:0] model_q[$];

  initial clk = 1'b0;
  always #10 clk = ~clk;

  bitmat_unit u_bitmat_unit (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (in_ready),
    .instr (instr), .src_a (src_a), .src_b (src_b), .out_valid (out_valid),
    .out_ready (out_ready), .out_result (out_result), .out_illegal (out_illegal)
  );

  bitmat_unit #(.XLEN(32)) u_bitmat_unit_narrow (
    .clk (clk), .rst_n (rst_n), .in_valid (n_in_valid), .in_ready (n_in_ready),
    .instr (n_instr), .src_a (n_src_a), .src_b (n_src_b), .out_valid (n_out_valid),
    .out_ready (n_out_ready), .out_result (n_out_result), .out_illegal (n_out_illegal)
  );

  function automatic logic [63:0] ref_flip(input logic [63:0] x);
    logic [63:0] y;
    for (int j = 0; j < 8; j++)
      for (int k = 0; k < 8; k++)
        y[8*k + j] = x[8*j + k];
    return y;
  endfunction

  function automatic logic [63:0] ref_prod(input logic [63:0] a, input logic [63:0] b,
                                           input bit parity);
    logic [63:0] y;
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++) begin
        logic acc;
        acc = 1'b0;
        for (int m = 0; m < 8; m++) begin
          if (parity) acc = acc ^ (a[8*r + m] & b[8*m + c]);
          else        acc = acc | (a[8*r + m] & b[8*m + c]);
        end
        y[8*r + c] = acc;
      end
    return y;
  endfunction

  function automatic logic [64:0] ref_exec(input logic [31:0] w, input logic [63:0] a,
                                           input logic [63:0] b);
    if (w[31:25] == 7'b0110000 && w[24:20] == 5'b00011 && w[14:12] == 3'b001 &&
        w[6:0] == 7'b0010011) return {1'b0, ref_flip(a)};
    if (w[14:12] == 3'b011 && w[6:0] == 7'b0110011) begin
      if (w[31:25] == 7'b0000100) return {1'b0, ref_prod(a, b, 1'b0)};
      if (w[31:25] == 7'b0100100) return {1'b0, ref_prod(a, b, 1'b1)};
    end
    return {1'b1, 64'd0};
  endfunction

  function automatic logic [31:0] enc_flip(input logic [4:0] rs1, input logic [4:0] rd);
    return {7'b0110000, 5'b00011, rs1, 3'b001, rd, 7'b0010011};
  endfunction

  function automatic logic [31:0] enc_prod(input logic [6:0] f7, input logic [4:0] rs2,
                                           input logic [4:0] rs1, input logic [4:0] rd);
    return {f7, rs2, rs1, 3'b011, rd, 7'b0110011};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [64:0] act,
                     input logic [64:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge: checks outputs, drives one cycle, updates model.
  task automatic step(input logic v, input logic [31:0] w, input logic [63:0] a,
                      input logic [63:0] b, input logic rdy, input string tag);
    logic exp_v;
    logic exp_rdy;
    exp_v = (model_q.size() > 0);
    chk(out_valid === exp_v, "R7 out_valid", {64'd0, out_valid}, {64'd0, exp_v});
    if (exp_v && out_valid)
      chk({out_illegal, out_result} === model_q[0], tag, {out_illegal, out_result}, model_q[0]);
    out_ready = rdy;
    in_valid  = v;
    instr     = w;
    src_a     = a;
    src_b     = b;
    #1;
    exp_rdy = !exp_v || rdy;
    chk(in_ready === exp_rdy, "R9 in_ready", {64'd0, in_ready}, {64'd0, exp_rdy});
    if (exp_v && rdy) void'(model_q.pop_front());
    if (v && exp_rdy) model_q.push_back(ref_exec(w, a, b));
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] ident;
    logic [63:0] y;
    ident = 64'h8040201008040201;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    instr = '0; src_a = '0; src_b = '0;
    n_in_valid = 1'b0; n_out_ready = 1'b1; n_instr = '0; n_src_a = '0; n_src_b = '0;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0 && out_result === 64'd0, "R1 in reset",
        {out_valid, out_result}, 65'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0 && out_result === 64'd0, "R1 after release",
        {out_valid, out_result}, 65'd0);

    // Transpose cases
    step(1, enc_flip(5'd1, 5'd2), ident, 64'hdead, 1, "R2 identity");
    step(1, enc_flip(5'd3, 5'd4), '1, 64'h0, 1, "R2 ones");
    step(1, enc_flip(5'd0, 5'd0), '0, '1, 1, "R2 zeros");
    step(1, enc_flip(5'd9, 5'd9), 64'h2, 64'h1234, 1, "R2 single bit");
    step(1, enc_flip(5'd9, 5'd9), 64'h2, 64'hffff_0000_5555_aaaa, 1, "R2 src_b ignored");
    step(0, '0, '0, '0, 1, "R2 drain");
    chk(out_result === 64'h100 && !out_illegal, "R2 single bit lands on bit 8",
        {out_illegal, out_result}, {1'b0, 64'h100});
    step(1, enc_flip(5'd5, 5'd6), 64'h0123_4567_89ab_cdef, 64'h0, 1, "R2 double a");
    y = out_result;
    step(1, enc_flip(5'd5, 5'd6), y, 64'h0, 1, "R2 double b");
    chk(out_result === 64'h0123_4567_89ab_cdef, "R2 flip twice returns input",
        {1'b0, out_result}, {1'b0, 64'h0123_4567_89ab_cdef});

    // Products and decode
    step(1, enc_prod(7'b0000100, 5'd2, 5'd1, 5'd3), 64'hf0e1_d2c3_b4a5_9687, ident, 1, "R3 A*I");
    step(1, enc_prod(7'b0100100, 5'd7, 5'd8, 5'd9), 64'hf0e1_d2c3_b4a5_9687, ident, 1, "R4 A*I");
    step(1, enc_prod(7'b0000100, 5'd2, 5'd1, 5'd3), '1, '1, 1, "R3 ones");
    step(1, enc_prod(7'b0100100, 5'd2, 5'd1, 5'd3), '1, '1, 1, "R4 ones even parity");
    step(1, enc_prod(7'b0000100, 5'd2, 5'd1, 5'd3), '0, '1, 1, "R3 zeros");
    step(1, enc_prod(7'b0100100, 5'd31, 5'd31, 5'd31), 64'h0f, 64'h0101_0101, 1, "R5 fields ignored");
    step(1, {7'b0110000, 5'b00010, 5'd1, 3'b001, 5'd2, 7'b0010011}, 64'h55, 0, 1, "R6 wrong sub field");
    step(1, {7'b0000100, 5'd1, 5'd1, 3'b010, 5'd2, 7'b0110011}, 64'h55, 1, 1, "R6 wrong funct3");
    step(1, {7'b0100100, 5'd1, 5'd1, 3'b011, 5'd2, 7'b0111011}, 64'h55, 1, 1, "R6 wrong opcode");
    step(1, 32'h0000_0013, '1, '1, 1, "R6 plain word");

    // Stall: result must hold while not ready
    step(1, enc_prod(7'b0100100, 5'd1, 5'd2, 5'd3), 64'h1234_5678_9abc_def0, 64'h0fed_cba9_8765_4321, 1, "R8 load");
    step(1, enc_flip(5'd1, 5'd1), 64'h77, 0, 0, "R8 hold 1");
    step(1, enc_flip(5'd1, 5'd1), 64'h77, 0, 0, "R8 hold 2");
    step(1, enc_flip(5'd1, 5'd1), 64'h77, 0, 0, "R8 hold 3");
    step(0, '0, '0, '0, 1, "R8 release");
    step(0, '0, '0, '0, 1, "R7 empty");

    // Narrow configuration
    n_in_valid = 1'b1;
    n_instr = enc_flip(5'd1, 5'd2);
    n_src_a = 32'hffff_ffff;
    @(negedge clk);
    n_in_valid = 1'b0;
    chk(n_out_valid === 1'b1 && n_out_illegal === 1'b1 && n_out_result === 32'd0,
        "R10 narrow flip", {n_out_valid, n_out_illegal, 31'd0, n_out_result},
        {1'b1, 1'b1, 63'd0});
    n_in_valid = 1'b1;
    n_instr = enc_prod(7'b0100100, 5'd1, 5'd2, 5'd3);
    @(negedge clk);
    n_in_valid = 1'b0;
    chk(n_out_valid === 1'b1 && n_out_illegal === 1'b1 && n_out_result === 32'd0,
        "R10 narrow product", {n_out_valid, n_out_illegal, 31'd0, n_out_result},
        {1'b1, 1'b1, 63'd0});

    // Randomized stream with random back-pressure
    for (int i = 0; i < 400; i++) begin
      logic [31:0] w;
      logic [63:0] a;
      logic [63:0] b;
      int sel;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      sel = $urandom % 4;
      case (sel)
        0: w = enc_flip(5'($urandom), 5'($urandom));
        1: w = enc_prod(7'b0000100, 5'($urandom), 5'($urandom), 5'($urandom));
        2: w = enc_prod(7'b0100100, 5'($urandom), 5'($urandom), 5'($urandom));
        default: w = $urandom;
      endcase
      step(1'($urandom % 3 != 0), w, a, b, 1'($urandom % 4 != 0),
           sel == 0 ? "R2 random" : sel == 1 ? "R3 random" : sel == 2 ? "R4 random" : "R6 random");
    end
    for (int i = 0; i < 4; i++) step(0, '0, '0, '0, 1, "R7 final drain");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule